// File: doc/BRIEF.md
# Flash Write Width Adapter

This block converts one 32-bit processor write into the sequence of narrow write cycles that an external ROM or Flash device needs. The device data bus is either 8 or 16 bits wide, chosen by a configuration input. A write that spans more byte lanes than the device width is issued as consecutive device cycles, starting at the lowest byte address. Each cycle holds the write strobe for a programmable number of wait clocks plus one, then leaves one idle clock. The processor is held off until a single-clock ready pulse marks the end of the whole write.

Flash accepts writes only in whole device-width units. A write whose byte enables are empty, have gaps, or do not split into whole device-width units is rejected. No device cycle is issued; instead the block returns ready together with an error pulse. Examples are a single byte to a 16-bit device, or three bytes to a 16-bit device, which would leave a half-filled second cycle.

The chip select is not decoded from programmable regions here. It comes from an external region-match input. The one exception is a fixed boot window covering the top 64 KiB of the 4 GiB space, which is active from reset with no programming needed.

Top module: `flash_wr_adapter`

## Requirements
- R1: On an 8-bit device a write is legal when its byte enables (bit n enables byte n, data bits 8n+7..8n) are non-zero and contiguous; otherwise ready and error are high together for one clock and no strobe is issued.
- R2: On a 16-bit device a write is legal only with byte enables 0011, 1100 or 1111; any other pattern (single bytes, three bytes, 0110, gaps, none) gets the R1 error response.
- R3: A legal write produces one device cycle per enabled byte on an 8-bit device and one per enabled byte pair on a 16-bit device (a 32-bit write gives four or two cycles).
- R4: The device address of the first cycle is the word-aligned processor address plus the lowest enabled byte index, and it increases by 1 (8-bit) or 2 (16-bit) for each later cycle.
- R5: Each cycle drives the data of its own byte lane (8-bit, in bits 7..0 with bits 15..8 zero) or byte pair (16-bit).
- R6: Each device cycle holds the write strobe for wait_i+1 clocks (wait_i 0 to 7, sampled at acceptance), followed by exactly one clock with the strobe low.
- R7: For a legal write, ready is high for exactly one clock: the idle clock of the last device cycle. Error stays low.
- R8: An access whose address bits 31..16 are all ones asserts the chip select during its strobe clocks, even with the region-match input low.
- R9: Outside the boot window the chip select follows the region-match input sampled at acceptance, and it is only ever high while the strobe is high.
- R10: While reset is asserted, strobe, chip select, ready and error are low.
- R11: A request presented while a write is in progress is ignored: it changes none of the cycles in progress and starts no cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, accepted on a clock edge while idle |
| addr_i | input | 32 | Processor byte address |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| dev16_i | input | 1 | Device width: 1 = 16-bit, 0 = 8-bit |
| wait_i | input | 3 | Wait clocks per device cycle |
| region_hit_i | input | 1 | External region match for chip select |
| dev_addr_o | output | 26 | Device byte address |
| dev_data_o | output | 16 | Device write data |
| dev_we_o | output | 1 | Device write strobe |
| dev_cs_o | output | 1 | Device chip select |
| rdy_o | output | 1 | Ready to processor, one-clock pulse |
| err_o | output | 1 | Illegal width error, pulses with ready |

## Verification
A request is taken at the clock edge where req_i is high and the block is idle. From the very next clock on, the outputs follow a fixed schedule. For a legal write, cycle k after acceptance (counting from 0) belongs to device cycle k/(wait+2) and carries the strobe when k mod (wait+2) is at most wait. Ready appears at k = n·(wait+2)−1, and the block is idle again at the clock after that. For an illegal write, ready and error both appear at k = 0 and the block is idle at k = 1. The bench drives inputs and samples at falling edges, one sample per cycle. It computes each cycle's expected strobe, ready, error, chip select, address and data from that formula. It sweeps both widths, all 16 byte-enable patterns and four wait settings.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
  localparam int CPU_BYTES = 4;
  localparam int LANE_W    = $clog2(CPU_BYTES);
  localparam int CNT_W     = LANE_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_STRB, ST_GAP, ST_ERR} fwa_st_e;

  typedef struct packed {
    logic              legal;
    logic [LANE_W-1:0] first;
    logic [CNT_W-1:0]  count;
  } fwa_plan_t;
endpackage

// File: rtl/fwa_lane_plan.sv
module fwa_lane_plan
  import fwa_pkg::*;
(
  input  logic [CPU_BYTES-1:0] be_i,
  input  logic                 dev16_i,
  output fwa_plan_t            plan_o
);
  logic [LANE_W-1:0]    lo, hi;
  logic [CPU_BYTES-1:0] span_mask;
  logic                 contig;
  logic [CNT_W-1:0]     span;

  always_comb begin
    lo = '0;
    hi = '0;
    for (int i = CPU_BYTES - 1; i >= 0; i--) if (be_i[i]) lo = LANE_W'(i);
    for (int i = 0; i < CPU_BYTES; i++)      if (be_i[i]) hi = LANE_W'(i);
  end

  for (genvar g = 0; g < CPU_BYTES; g++) begin : g_mask
    assign span_mask[g] = (LANE_W'(g) >= lo) && (LANE_W'(g) <= hi);
  end

  assign contig = (be_i != '0) && (be_i == span_mask);
  assign span   = CNT_W'(hi) - CNT_W'(lo) + CNT_W'(1);

  // 16-bit units must start on an even lane and end on an odd one
  assign plan_o.legal = contig && (!dev16_i || (!lo[0] && hi[0]));
  assign plan_o.first = lo;
  assign plan_o.count = dev16_i ? (span >> 1) : span;
endmodule

// File: rtl/fwa_boot_dec.sv
module fwa_boot_dec #(
  parameter int          ADDR_W   = 32,
  parameter int          TAG_W    = 16,
  parameter logic [15:0] BOOT_TAG = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              region_hit_i,
  output logic              sel_o
);
  assign sel_o = (addr_i[ADDR_W-1 -: TAG_W] == BOOT_TAG[TAG_W-1:0]) || region_hit_i;
endmodule

// File: rtl/fwa_seq.sv
module fwa_seq
  import fwa_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  fwa_plan_t         plan_i,
  input  logic              dev16_i,
  input  logic [WS_W-1:0]   ws_i,
  output logic              accept_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              we_o,
  output logic              rdy_o,
  output logic              err_o
);
  fwa_st_e           st_q;
  logic [WS_W-1:0]   wcnt_q, ws_q;
  logic [LANE_W-1:0] lane_q, step_q;
  logic [CNT_W-1:0]  left_q;

  assign accept_o = req_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      ws_q   <= '0;
      lane_q <= '0;
      step_q <= '0;
      left_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          if (plan_i.legal) begin
            st_q   <= ST_STRB;
            wcnt_q <= ws_i;
            ws_q   <= ws_i;
            lane_q <= plan_i.first;
            left_q <= plan_i.count;
            step_q <= dev16_i ? LANE_W'(2) : LANE_W'(1);
          end else begin
            st_q <= ST_ERR;
          end
        end
        ST_STRB: begin
          if (wcnt_q == '0) st_q <= ST_GAP;
          else              wcnt_q <= wcnt_q - 1'b1;
        end
        ST_GAP: begin
          if (left_q == CNT_W'(1)) begin
            st_q <= ST_IDLE;
          end else begin
            st_q   <= ST_STRB;
            left_q <= left_q - 1'b1;
            lane_q <= lane_q + step_q;
            wcnt_q <= ws_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign lane_o = lane_q;
  assign we_o   = (st_q == ST_STRB);
  assign rdy_o  = (st_q == ST_ERR) || ((st_q == ST_GAP) && (left_q == CNT_W'(1)));
  assign err_o  = (st_q == ST_ERR);
endmodule

// File: rtl/flash_wr_adapter.sv
module flash_wr_adapter
  import fwa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEV_AW = 26,
  parameter int DEV_DW = 16,
  parameter int WS_W   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [CPU_BYTES-1:0]   be_i,
  input  logic [8*CPU_BYTES-1:0] wdata_i,
  input  logic                   dev16_i,
  input  logic [WS_W-1:0]        wait_i,
  input  logic                   region_hit_i,
  output logic [DEV_AW-1:0]      dev_addr_o,
  output logic [DEV_DW-1:0]      dev_data_o,
  output logic                   dev_we_o,
  output logic                   dev_cs_o,
  output logic                   rdy_o,
  output logic                   err_o
);
  localparam int CPU_DW = 8 * CPU_BYTES;

  fwa_plan_t         plan;
  logic              accept, sel, we;
  logic [LANE_W-1:0] lane;

  logic [DEV_AW-LANE_W-1:0] base_q;
  logic [CPU_DW-1:0]        data_q;
  logic                     sel_q, dev16_q;
  logic                     unused_lsb;

  assign unused_lsb = ^addr_i[LANE_W-1:0];

  fwa_lane_plan u_plan (
    .be_i    (be_i),
    .dev16_i (dev16_i),
    .plan_o  (plan)
  );

  fwa_boot_dec #(.ADDR_W(ADDR_W)) u_boot (
    .addr_i       (addr_i),
    .region_hit_i (region_hit_i),
    .sel_o        (sel)
  );

  fwa_seq #(.WS_W(WS_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .plan_i   (plan),
    .dev16_i  (dev16_i),
    .ws_i     (wait_i),
    .accept_o (accept),
    .lane_o   (lane),
    .we_o     (we),
    .rdy_o    (rdy_o),
    .err_o    (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      data_q  <= '0;
      sel_q   <= 1'b0;
      dev16_q <= 1'b0;
    end else if (accept) begin
      base_q  <= addr_i[DEV_AW-1:LANE_W];
      data_q  <= wdata_i;
      sel_q   <= sel;
      dev16_q <= dev16_i;
    end
  end

  assign dev_addr_o = {base_q, lane};
  assign dev_data_o = dev16_q ? data_q[{lane[LANE_W-1:1], 4'b0000} +: 16]
                              : {8'h00, data_q[{lane, 3'b000} +: 8]};
  assign dev_we_o   = we;
  assign dev_cs_o   = we && sel_q;
endmodule

// File: rtl/fwa_chk.sv
module fwa_chk #(
  parameter int DEV_AW = 26,
  parameter int DEV_DW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DEV_AW-1:0] dev_addr_o,
  input logic [DEV_DW-1:0] dev_data_o,
  input logic              dev_we_o,
  input logic              dev_cs_o,
  input logic              rdy_o,
  input logic              err_o
);
  a_r7_rdy_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);

  a_r1_err_with_rdy_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdy_o && !dev_we_o));

  a_r9_cs_within_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_cs_o |-> dev_we_o);

  a_r4_addr_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_we_o && $past(dev_we_o)) |-> ($stable(dev_addr_o) && $stable(dev_data_o)));

  a_r6_gap_before_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !err_o) |-> (!dev_we_o && $past(dev_we_o)));

  a_r11_idle_after_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> (!dev_we_o && !err_o));
endmodule

bind flash_wr_adapter fwa_chk #(.DEV_AW(DEV_AW), .DEV_DW(DEV_DW)) u_fwa_chk (.*);

// File: tb/flash_wr_adapter_bench.sv
module flash_wr_adapter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic        dev16_i = 1'b0;
  logic [2:0]  wait_i = '0;
  logic        region_hit_i = 1'b0;
  logic [25:0] dev_addr_o;
  logic [15:0] dev_data_o;
  logic        dev_we_o, dev_cs_o, rdy_o, err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;

  flash_wr_adapter u_flash_wr_adapter (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic run_txn(input bit d16, input logic [3:0] be, input int ws,
                         input logic [31:0] addr, input logic [31:0] data, input bit hit);
    int lo = 0, hi = 0, w, n, per, total, strobes = 0;
    bit cont, legal, bsel, prev_we = 1'b0;
    logic [31:0] exp_mask;
    for (int i = 3; i >= 0; i--) if (be[i]) lo = i;
    for (int i = 0; i < 4; i++)  if (be[i]) hi = i;
    exp_mask = (32'd1 << (hi + 1)) - (32'd1 << lo);
    cont  = (be != 4'd0) && ({28'd0, be} == exp_mask);
    legal = d16 ? (cont && (lo % 2 == 0) && (hi % 2 == 1)) : cont;
    w     = d16 ? 2 : 1;
    n     = legal ? (hi - lo + 1) / w : 0;
    per   = ws + 2;
    total = legal ? n * per : 1;
    bsel  = (addr[31:16] == 16'hFFFF) || hit;

    @(negedge clk_i);
    req_i = 1'b1; be_i = be; addr_i = addr; wdata_i = data;
    dev16_i = d16; wait_i = 3'(ws); region_hit_i = hit;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int k = 0; k < total; k++) begin
      int s, ph;
      bit e_we, e_rdy;
      logic [31:0] e_addr, e_data;
      if (k > 0) @(negedge clk_i);
      if (k == 1) req_i = 1'b0;
      s  = k / per;
      ph = k % per;
      e_we  = legal && (ph <= ws);
      e_rdy = legal ? (k == total - 1) : 1'b1;
      if (!legal) begin
        chk(d16 ? "R2 err" : "R1 err", {31'd0, err_o}, 32'd1);
        chk(d16 ? "R2 rdy" : "R1 rdy", {31'd0, rdy_o}, 32'd1);
      end else begin
        chk("R7 err low", {31'd0, err_o}, 32'd0);
        chk("R7 rdy", {31'd0, rdy_o}, {31'd0, e_rdy});
      end
      chk("R6 strobe", {31'd0, dev_we_o}, {31'd0, e_we});
      chk(bsel ? "R8 cs" : "R9 cs", {31'd0, dev_cs_o}, {31'd0, e_we && bsel});
      if (e_we) begin
        e_addr = ((addr & 32'hFFFF_FFFC) + 32'(lo + s * w)) & 32'h03FF_FFFF;
        e_data = d16 ? ((data >> (8 * (lo + 2 * s))) & 32'hFFFF)
                     : ((data >> (8 * (lo + s))) & 32'hFF);
        chk("R4 addr", {6'd0, dev_addr_o}, e_addr);
        chk("R5 data", {16'd0, dev_data_o}, e_data);
      end
      if (dev_we_o && !prev_we) strobes++;
      prev_we = dev_we_o;
      if (k == 0 && total > 1) begin
        // R11: request while busy with different content
        req_i = 1'b1; be_i = 4'hF; addr_i = ~addr; wdata_i = ~data;
        dev16_i = ~d16; wait_i = 3'd0; region_hit_i = ~hit;
      end
    end
    chk(d16 ? "R3 cycles 16" : "R3 cycles 8", 32'(strobes), 32'(n));
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R11 idle after", {28'd0, dev_we_o, dev_cs_o, rdy_o, err_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset", {28'd0, dev_we_o, dev_cs_o, rdy_o, err_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 idle", {28'd0, dev_we_o, dev_cs_o, rdy_o, err_o}, 32'd0);
    begin
      int idx = 0;
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 16; b++)
          for (int wi = 0; wi < 4; wi++) begin
            logic [31:0] a;
            a = (idx % 3 == 0) ? (32'hFFFF_0000 | ((idx * 52) & 32'hFFFF))
                               : (32'h0040_0000 + 32'(idx * 36));
            run_txn(d[0], 4'(b), (wi == 3) ? 7 : wi, a,
                    32'hA5C3_1E70 ^ 32'(idx * 32'h0101_0107), (idx % 3 == 1));
            idx++;
          end
    end
    // R8 window edges
    run_txn(1'b0, 4'h1, 0, 32'hFFFE_FFFF, 32'h0000_0042, 1'b0);
    run_txn(1'b1, 4'h3, 1, 32'hFFFF_0000, 32'h0000_BEEF, 1'b0);
    run_txn(1'b0, 4'hF, 2, 32'hFFFF_FFFC, 32'h1234_5678, 1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule